// File: doc/BRIEF.md
# Unaligned Word Load Sequencer

This block accepts a byte-addressed load and returns a 32-bit little-endian word. It reads from a memory made of four byte-wide banks that all share one word-offset address. Byte address `4N+k` lives in bank `k` at word offset `N`, and bank `k` always drives read-data bits `8k+7:8k`. Because all four banks share one offset, one memory read can only return one aligned word.

A load whose two low address bits are zero costs one memory read. Any other byte offset costs two reads at consecutive word offsets, `N` and then `N+1`. The bytes from both reads are then shifted into place. Bytes of the first word at or above the byte offset become the low bytes of the result. Bytes of the second word below the byte offset become the high bytes. The response carries a flag that tells the requester whether the load needed two reads.

The memory port has a one-cycle read latency. Only one load is in flight at a time: the request port is not ready from acceptance until the response has been delivered.

Top module: `unaligned_load_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and both `rsp_valid` and `mem_rd` are 0. A reset in mid-transaction drops that load, and no response is produced for it.
- R2: In the cycle where `req_valid` and `req_ready` are both 1, `mem_rd` is 1 and `mem_addr` equals `req_addr[ADDR_W-1:2]`.
- R3: `req_ready` is 0 from the cycle after acceptance until the cycle after `rsp_valid`. Requests presented during that window cause no memory read and no response.
- R4: For a load with `req_addr[1:0] == 0`, exactly one memory read is issued. `rsp_valid` is 1 two cycles after the acceptance cycle, `rsp_data` equals the word read, and `rsp_split` is 0.
- R5: For a load with `req_addr[1:0] != 0`, a second read is issued in the cycle after acceptance at word offset `req_addr[ADDR_W-1:2] + 1`. `rsp_valid` is 1 three cycles after the acceptance cycle, and `rsp_split` is 1.
- R6: `rsp_data[8i+7:8i]` equals the memory byte at byte address `req_addr + i` for i = 0..3, for every byte offset. Memory data is little-endian, with bank `k` on `mem_rdata[8k+7:8k]`.
- R7: A misaligned load in the last word of the address space reads its second word at offset 0, and byte addresses wrap modulo `2**ADDR_W`.
- R8: `rsp_valid` is a one-cycle pulse, and `req_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| req_ready | output | 1 | Sequencer idle; request taken when valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Loaded word, little-endian |
| rsp_split | output | 1 | Load took two memory reads |
| mem_addr | output | ADDR_W-2 | Word offset shared by all four banks |
| mem_rd | output | 1 | Memory read enable |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
The bound checker checks these rules on every cycle:
- the memory address driven at acceptance;
- the ready gap after acceptance;
- the `+1` word offset of the second read, including wrap-around;
- the response latency for both split and unsplit loads;
- the aligned response data against the word read the cycle before;
- the single-cycle response strobe.

The byte merge for offsets 1 to 3, the exact count of reads per load, the ignoring of requests while busy, and the recovery from a reset in mid-load can only be shown by the bench scenarios. The bench compares each result against byte values computed from the address.

// File: rtl/unaligned_load_seq.sv
module unaligned_load_seq #(
  parameter int ADDR_W = 16,
  localparam int OFS_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_split,
  output logic [OFS_W-1:0]  mem_addr,
  output logic              mem_rd,
  input  logic [31:0]       mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_RESP} state_t;

  state_t           state;
  logic [OFS_W-1:0] base;
  logic [1:0]       lane;
  logic [31:0]      low_word;
  logic [63:0]      pair;
  logic [31:0]      merged;
  logic             accept;
  logic             second_rd;

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign accept    = req_valid & req_ready;
  assign second_rd = (state == S_FIRST) && (lane != 2'd0);
  assign mem_rd    = accept | second_rd;
  assign mem_addr  = accept ? req_addr[ADDR_W-1:2] : base + OFS_W'(1);

  assign pair   = {mem_rdata, low_word};
  assign merged = pair[{lane, 3'b000} +: 32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base      <= '0;
      lane      <= '0;
      low_word  <= '0;
      rsp_data  <= '0;
      rsp_split <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          base  <= req_addr[ADDR_W-1:2];
          lane  <= req_addr[1:0];
          state <= S_FIRST;
        end
        S_FIRST: if (lane == 2'd0) begin
          rsp_data  <= mem_rdata;
          rsp_split <= 1'b0;
          state     <= S_RESP;
        end else begin
          low_word <= mem_rdata;
          state    <= S_SECOND;
        end
        S_SECOND: begin
          rsp_data  <= merged;
          rsp_split <= 1'b1;
          state     <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/unaligned_load_seq_chk.sv
module unaligned_load_seq_chk #(
  parameter int ADDR_W = 16,
  localparam int OFS_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic              rsp_split,
  input logic [OFS_W-1:0]  mem_addr,
  input logic              mem_rd,
  input logic [31:0]       mem_rdata
);

  // R2
  accept_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (mem_rd && mem_addr == req_addr[ADDR_W-1:2]));

  // R3
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5 R7
  second_read_next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !req_ready) |-> (mem_addr == OFS_W'($past(mem_addr) + 1'b1)));

  // R4
  single_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_split) |-> $past(req_valid && req_ready, 2));

  // R5
  split_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_split) |-> $past(req_valid && req_ready, 3));

  // R4
  aligned_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_split) |-> (rsp_data == $past(mem_rdata)));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

bind unaligned_load_seq unaligned_load_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_split(rsp_split), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_rdata(mem_rdata)
);

// File: tb/unaligned_load_seq_bench.sv
module unaligned_load_seq_bench;
  localparam int AW = 16;
  localparam int OW = AW - 2;
  localparam int NV = 10;
  // {addr, expected split, expected latency}
  localparam logic [19:0] VEC [NV] = '{
    {16'h0000, 1'b0, 3'd2}, {16'h0001, 1'b1, 3'd3}, {16'h0002, 1'b1, 3'd3},
    {16'h0003, 1'b1, 3'd3}, {16'h0004, 1'b0, 3'd2}, {16'h1235, 1'b1, 3'd3},
    {16'h7FFF, 1'b1, 3'd3}, {16'hFFFC, 1'b0, 3'd2}, {16'hFFFD, 1'b1, 3'd3},
    {16'hFFFF, 1'b1, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_split, mem_rd;
  logic [31:0] rsp_data;
  logic [31:0] mem_rdata = 32'hDEADBEEF;
  logic [OW-1:0] mem_addr;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  unaligned_load_seq #(.ADDR_W(AW)) u_unaligned_load_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_split(rsp_split), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] byte_at(logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [31:0] word_at(logic [OW-1:0] n);
    logic [AW-1:0] b = {n, 2'b00};
    return {byte_at(b + 16'd3), byte_at(b + 16'd2), byte_at(b + 16'd1), byte_at(b)};
  endfunction

  function automatic logic [31:0] load_at(logic [AW-1:0] a);
    return {byte_at(a + 16'd3), byte_at(a + 16'd2), byte_at(a + 16'd1), byte_at(a)};
  endfunction

  always @(posedge clk) mem_rdata <= mem_rd ? word_at(mem_addr) : 32'hDEADBEEF;

  task automatic chk(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_load(logic [AW-1:0] addr, logic exp_split, int exp_lat, logic hold);
    int nreads = 0;
    int lat = 0;
    logic [OW-1:0] rd2 = '0;
    logic [OW-1:0] exp2;
    exp2 = addr[AW-1:2] + 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    #1;
    chk("R3 ready before accept", req_ready == 1'b1, 32'(req_ready), 32'd1);
    chk("R2 accept read", mem_rd && mem_addr == addr[AW-1:2], 32'(mem_addr), 32'(addr[AW-1:2]));
    for (int c = 1; c <= 6 && lat == 0; c++) begin
      @(negedge clk);
      if (req_ready) chk("R3 ready low while busy", 1'b0, 32'd1, 32'd0);
      if (mem_rd) begin nreads++; rd2 = mem_addr; end
      if (rsp_valid) lat = c;
      if (hold && lat == 0) req_addr = addr ^ 16'h0405;
      else req_valid = 1'b0;
    end
    chk(exp_split ? "R5 latency" : "R4 latency", lat == exp_lat, 32'(lat), 32'(exp_lat));
    chk("R3 reads per load", nreads == int'(exp_split), 32'(nreads), 32'(exp_split));
    if (exp_split)
      chk(addr[AW-1:2] == '1 ? "R7 wrapped offset" : "R5 second offset",
          rd2 == exp2, 32'(rd2), 32'(exp2));
    chk(exp_split ? "R6 merged data" : "R4 data", rsp_data == load_at(addr), rsp_data, load_at(addr));
    chk("R5 split flag", rsp_split == exp_split, 32'(rsp_split), 32'(exp_split));
    @(negedge clk);
    chk("R8 pulse end", !rsp_valid && req_ready, {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset held", req_ready && !rsp_valid && !mem_rd,
        {29'd0, req_ready, rsp_valid, mem_rd}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", req_ready && !rsp_valid && !mem_rd,
        {29'd0, req_ready, rsp_valid, mem_rd}, 32'd4);

    for (int i = 0; i < NV; i++)
      run_load(VEC[i][19:4], VEC[i][3], int'(VEC[i][2:0]), i[0]);

    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'h0203;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n     = 1'b0;
    @(negedge clk);
    chk("R1 mid-load reset", req_ready && !rsp_valid && !mem_rd,
        {29'd0, req_ready, rsp_valid, mem_rd}, 32'd4);
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rsp_valid) chk("R1 dropped load response", 1'b0, 32'd1, 32'd0);
    end
    chk("R1 idle after mid-load reset", req_ready == 1'b1, 32'(req_ready), 32'd1);
    run_load(16'h0203, 1'b1, 3, 1'b0);
    run_load(16'hFFFE, 1'b1, 3, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule